// File: doc/BRIEF.md
# Half-Duplex Turnaround Timeout Timer

This block keeps one 8-bit turnaround timeout and measures it out in steps of 100 µs. Two register ports can write the timeout. One is a configuration-space port that is open only while the chip is in configuration state and the selected index is 0x2D. The other is a serial-engine port at block 5, offset 1. There is one storage byte behind both ports, so the latest write from either port is what both of them read back.

A one-cycle start strobe loads a down-counter from the stored value and raises `busy`. A built-in prescaler produces one tick every `TICK_CYCLES` clocks, and each tick takes one from the counter. When the counter reaches zero, `busy` drops and `done` pulses for one cycle. A serial-engine soft reset stops a count that is running and leaves the stored value as it is. Only the power-on reset puts the default back.

Top module: `hd_turnaround_timer`

## Requirements
- R1: While `por_n` is low and after it is released, `value` reads 0x03 and both `busy` and `done` read 0.
- R2: A cycle with `cfg_mode`=1, `cfg_index`=0x2D and `cfg_we`=1 loads `cfg_wdata` into `value` on the next clock edge.
- R3: A cycle with `eng_we`=1, `eng_block`=5 and `eng_addr`=1 loads `eng_wdata` into `value` on the next clock edge.
- R4: A write with `cfg_mode`=0, any other configuration index, or any other engine block or offset leaves `value` unchanged.
- R5: When both ports write in the same cycle, the configuration port's data is stored.
- R6: A start with stored value N≥1 raises `busy` at the next edge. The edge on which `done` rises and `busy` falls comes N×`TICK_CYCLES` clock cycles after the start edge. `done` stays high for exactly one cycle.
- R7: A start with stored value 0 raises `done` at the next edge, for one cycle, and `busy` stays 0.
- R8: A start while `busy` is high restarts the count and the prescaler from the current stored value. No `done` comes from the abandoned count.
- R9: `soft_rst` clears `busy` at the next edge and suppresses `done`, and `value` is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| soft_rst | input | 1 | Serial-engine soft reset, synchronous, active high |
| cfg_mode | input | 1 | High while the chip is in configuration state |
| cfg_index | input | 8 | Selected configuration register index |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| eng_block | input | 3 | Serial-engine register block select |
| eng_addr | input | 3 | Serial-engine register offset |
| eng_we | input | 1 | Serial-engine write strobe |
| eng_wdata | input | 8 | Serial-engine write data |
| start | input | 1 | Starts (or restarts) a turnaround count |
| value | output | 8 | Shared stored timeout, in 100 µs units |
| busy | output | 1 | High while a count is running |
| done | output | 1 | One-cycle pulse when a count ends |

## Verification
A write shows on `value` one edge after the write cycle. `done` and the fall of `busy` come N×`TICK_CYCLES`+1 edges after the start cycle, with the start edge counted as the first. For N=0 that is a single edge. The bench drives and samples on the falling edge. It counts rising edges from the start strobe until `done` is seen and compares the count with that formula. It then checks that `done` is low one edge later. The soft-reset and restart cases also watch `done` through the whole window in which a stale pulse could appear.

// File: rtl/hd_turnaround_timer.sv
module hd_turnaround_timer #(
  parameter int          TICK_CYCLES = 12500,
  parameter logic [7:0]  CFG_INDEX   = 8'h2D,
  parameter logic [2:0]  ENG_BLOCK   = 3'd5,
  parameter logic [2:0]  ENG_ADDR    = 3'd1,
  parameter logic [7:0]  RESET_VALUE = 8'h03
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       soft_rst,
  input  logic       cfg_mode,
  input  logic [7:0] cfg_index,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  input  logic [2:0] eng_block,
  input  logic [2:0] eng_addr,
  input  logic       eng_we,
  input  logic [7:0] eng_wdata,
  input  logic       start,
  output logic [7:0] value,
  output logic       busy,
  output logic       done
);

  localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(TICK_CYCLES - 1);

  logic          cfg_hit, eng_hit, tick, go;
  logic [PW-1:0] pre;
  logic [7:0]    cnt;

  assign cfg_hit = cfg_mode && cfg_we && (cfg_index == CFG_INDEX);
  assign eng_hit = eng_we && (eng_block == ENG_BLOCK) && (eng_addr == ENG_ADDR);
  assign tick    = busy && (pre == PRE_LAST);
  assign go      = start && !soft_rst;

  // shared storage: configuration port wins a same-cycle collision
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       value <= RESET_VALUE;
    else if (cfg_hit) value <= cfg_wdata;
    else if (eng_hit) value <= eng_wdata;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                    pre <= '0;
    else if (soft_rst || start)    pre <= '0;
    else if (busy)                 pre <= tick ? '0 : pre + 1'b1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else if (soft_rst) begin
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else if (go) begin
      cnt  <= value;
      busy <= (value != 8'd0);
      done <= (value == 8'd0);
    end else if (tick) begin
      cnt  <= cnt - 1'b1;
      busy <= (cnt != 8'd1);
      done <= (cnt == 8'd1);
    end else begin
      done <= 1'b0;
    end
  end

  a_r4_hold_without_write: assert property (@(posedge clk) disable iff (!por_n)
    (!cfg_hit && !eng_hit) |=> $stable(value));

  a_r5_cfg_wins: assert property (@(posedge clk) disable iff (!por_n)
    (cfg_hit && eng_hit) |=> (value == $past(cfg_wdata)));

  a_r6_done_one_cycle: assert property (@(posedge clk) disable iff (!por_n)
    done |=> !done);

  a_r6_done_not_busy: assert property (@(posedge clk) disable iff (!por_n)
    done |-> !busy);

  a_r6_start_raises_busy: assert property (@(posedge clk) disable iff (!por_n)
    (go && value != 8'd0) |=> (busy && !done));

  a_r7_zero_immediate: assert property (@(posedge clk) disable iff (!por_n)
    (go && value == 8'd0) |=> (done && !busy));

  a_r9_soft_abort: assert property (@(posedge clk) disable iff (!por_n)
    soft_rst |=> (!busy && !done));

endmodule

// File: tb/sim_hd_turnaround_timer.sv
`timescale 1ns/1ps
module sim_hd_turnaround_timer;
  localparam int TICK = 4;

  logic clk = 1'b0, por_n = 1'b0, soft_rst = 1'b0;
  logic cfg_mode = 1'b0, cfg_we = 1'b0, eng_we = 1'b0, start = 1'b0;
  logic [7:0] cfg_index = 8'h00, cfg_wdata = 8'h00, eng_wdata = 8'h00;
  logic [2:0] eng_block = 3'd0, eng_addr = 3'd0;
  logic [7:0] value;
  logic busy, done;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  hd_turnaround_timer #(.TICK_CYCLES(TICK)) u0 (
    .clk(clk), .por_n(por_n), .soft_rst(soft_rst),
    .cfg_mode(cfg_mode), .cfg_index(cfg_index), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .eng_block(eng_block), .eng_addr(eng_addr), .eng_we(eng_we), .eng_wdata(eng_wdata),
    .start(start), .value(value), .busy(busy), .done(done));

  // fields: port (1=engine), hit, data, expected value
  localparam logic [17:0] VEC [8] = '{
    {1'b0, 1'b1, 8'h05, 8'h05},
    {1'b1, 1'b1, 8'h02, 8'h02},
    {1'b0, 1'b0, 8'h40, 8'h02},
    {1'b1, 1'b0, 8'h40, 8'h02},
    {1'b1, 1'b1, 8'h00, 8'h00},
    {1'b0, 1'b1, 8'h01, 8'h01},
    {1'b1, 1'b1, 8'h07, 8'h07},
    {1'b0, 1'b1, 8'h0A, 8'h0A}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input bit eng, input bit hit, input logic [7:0] d);
    if (eng) begin
      eng_we = 1'b1; eng_wdata = d; eng_addr = 3'd1;
      eng_block = hit ? 3'd5 : 3'd3;
    end else begin
      cfg_we = 1'b1; cfg_wdata = d; cfg_index = 8'h2D;
      cfg_mode = hit;
    end
    @(negedge clk);
    eng_we = 1'b0; cfg_we = 1'b0; cfg_mode = 1'b0;
  endtask

  task automatic run(input int n, input string req);
    int lat;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    chk(busy == (n != 0), req, busy, n != 0);
    while (!done && lat < 2000) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == n * TICK + 1, req, lat, n * TICK + 1);
    @(negedge clk);
    chk(!done && !busy, req, {done, busy}, 0);
  endtask

  task automatic tests();
    int seen;
    @(negedge clk);
    chk(value == 8'h03 && !busy && !done, "R1", value, 3);
    por_n = 1'b1;
    @(negedge clk);
    chk(value == 8'h03 && !busy && !done, "R1", value, 3);
    run(3, "R6");

    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][17], VEC[i][16], VEC[i][15:8]);
      chk(value == VEC[i][7:0], VEC[i][16] ? (VEC[i][17] ? "R3" : "R2") : "R4",
          value, VEC[i][7:0]);
      run(int'(VEC[i][7:0]), VEC[i][7:0] == 0 ? "R7" : "R6");
    end

    // R4: configuration mode with a different index
    cfg_mode = 1'b1; cfg_index = 8'h2C; cfg_wdata = 8'h99; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; cfg_mode = 1'b0;
    chk(value == 8'h0A, "R4", value, 8'h0A);
    // R4: right engine block, wrong offset
    eng_we = 1'b1; eng_block = 3'd5; eng_addr = 3'd2; eng_wdata = 8'h99;
    @(negedge clk);
    eng_we = 1'b0;
    chk(value == 8'h0A, "R4", value, 8'h0A);

    // R5: collision
    cfg_mode = 1'b1; cfg_index = 8'h2D; cfg_we = 1'b1; cfg_wdata = 8'h11;
    eng_we = 1'b1; eng_block = 3'd5; eng_addr = 3'd1; eng_wdata = 8'h22;
    @(negedge clk);
    cfg_we = 1'b0; cfg_mode = 1'b0; eng_we = 1'b0;
    chk(value == 8'h11, "R5", value, 8'h11);

    // R9: soft reset mid-count keeps value and kills done
    wr(1'b1, 1'b1, 8'h0A);
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (5) @(negedge clk);
    soft_rst = 1'b1; @(negedge clk); soft_rst = 1'b0;
    chk(!busy, "R9", busy, 0);
    seen = 0;
    repeat (60) begin @(negedge clk); if (done) seen++; end
    chk(seen == 0, "R9", seen, 0);
    chk(value == 8'h0A, "R9", value, 8'h0A);

    // R8: restart while busy
    start = 1'b1; @(negedge clk); start = 1'b0;
    seen = 0;
    repeat (19) begin @(negedge clk); if (done) seen++; end
    chk(busy, "R8", busy, 1);
    run(10, "R8");
    chk(seen == 0, "R8", seen, 0);

    // R6: full-scale value
    wr(1'b1, 1'b1, 8'hFF);
    run(255, "R6");

    // R1: power-on reset restores default
    por_n = 1'b0;
    #1;
    chk(value == 8'h03, "R1", value, 3);
    @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    chk(value == 8'h03 && !busy, "R1", value, 3);
  endtask

  initial begin
    fork
      tests();
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule